// File: doc/BRIEF.md
# Fetch Thread Selector

This block decides, every cycle, which hardware thread the instruction fetch stage serves next. It reads a small status code and an active bit for each thread, a policy code, and a per-thread queue-occupancy count, and it returns a thread index with a valid flag. The choice is purely combinational, so the fetch stage can use it in the same cycle it is offered.

Three policies are available. The fixed policy always points at thread 0. The rotating policy keeps an ordered priority list of thread numbers: the first thread on that list that is allowed to fetch wins, and when the fetch stage accepts the choice with the `take_i` strobe, that thread leaves its position and joins the end of the list. The occupancy policy picks the thread with the largest count among those allowed to fetch. When the block is built for a single thread, the policy input plays no part.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread can be chosen only when its active bit is 1 and its 3-bit status is one of 0 (running), 1 (idle) or 6 (fill complete); codes 2, 3, 4, 5 and 7 (squashing, blocked, waiting for a fill, waiting to retry, reserved) exclude it.
- R2: Under policy code 1 (rotating), the output is the first thread that R1 allows, scanning the priority list from its head.
- R3: In a cycle with policy code 1, `valid_o` high and `take_i` high, the chosen thread moves to the tail of the list on the next clock edge and the other threads keep their relative order.
- R4: When no thread qualifies under the active policy, `valid_o` is 0 and `tid_o` is 0.
- R5: After reset the priority list holds the thread numbers in ascending order, thread 0 at its head.
- R6: With more than one thread, policy code 0 (fixed) returns thread 0 with `valid_o` high, whatever the statuses.
- R7: Under policy code 2 (occupancy), the output is the qualifying thread with the largest `occ_i` count; of equal counts, the lower thread number wins.
- R8: Policy code 3 is unsupported and yields `valid_o` low.
- R9: The priority list does not change when `take_i` is low, when `valid_o` is low, or when the policy code is not 1.
- R10: With one thread configured, the policy code is ignored: `valid_o` follows R1 for thread 0 and `tid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | Policy code: 0 fixed, 1 rotating, 2 occupancy, 3 unsupported |
| status_i | input | 3*NUM_THREADS | Status code per thread, thread t in bits [3t+2:3t] |
| active_i | input | NUM_THREADS | Active bit per thread |
| occ_i | input | CNT_W*NUM_THREADS | Queue occupancy per thread, thread t in bits [CNT_W*t +: CNT_W] |
| take_i | input | 1 | Fetch stage accepts the current choice |
| valid_o | output | 1 | A thread was chosen |
| tid_o | output | TID_W | Chosen thread number |

## Verification
The selection and the list update share a cycle whenever `take_i` is high: the output for that cycle must come from the old list order while the list reorders at the edge. The bench provokes this by taking back-to-back choices under the rotating policy, and by asserting `take_i` while the occupancy, fixed or unsupported policy is selected or while nothing qualifies, then returning to the rotating policy and judging from the next choice whether the list moved. A scoreboard model that keeps its own copy of the list predicts each output.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    localparam int ST_W  = 3;
    localparam int POL_W = 2;

    typedef enum logic [ST_W-1:0] {
        ST_RUN        = 3'd0,
        ST_IDLE       = 3'd1,
        ST_SQUASH     = 3'd2,
        ST_BLOCKED    = 3'd3,
        ST_WAIT_FILL  = 3'd4,
        ST_WAIT_RETRY = 3'd5,
        ST_FILL_DONE  = 3'd6,
        ST_RSVD       = 3'd7
    } thr_state_e;

    typedef enum logic [POL_W-1:0] {
        POL_FIXED  = 2'd0,
        POL_ROTATE = 2'd1,
        POL_OCC    = 2'd2,
        POL_NONE   = 2'd3
    } policy_e;

    // A thread may be served only in these states
    function automatic logic state_can_fetch(input logic [ST_W-1:0] s);
        return (s == ST_RUN) || (s == ST_IDLE) || (s == ST_FILL_DONE);
    endfunction

endpackage

// File: rtl/fsel_elig.sv
module fsel_elig #(
    parameter int NUM_THREADS = 4
) (
    input  logic [NUM_THREADS*fsel_pkg::ST_W-1:0] status_i,
    input  logic [NUM_THREADS-1:0]                active_i,
    output logic [NUM_THREADS-1:0]                elig_o
);
    import fsel_pkg::*;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assign elig_o[t] = active_i[t] & state_can_fetch(status_i[t*ST_W +: ST_W]);
    end

endmodule

// File: rtl/fsel_rr_list.sv
module fsel_rr_list #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NUM_THREADS-1:0] elig_i,
    input  logic                   advance_i,
    output logic                   hit_o,
    output logic [TID_W-1:0]       win_o
);

    typedef struct packed {
        logic [NUM_THREADS-1:0][TID_W-1:0] order;
    } rr_state_t;

    rr_state_t state_d, state_q;
    logic [TID_W-1:0] pos;

    always_comb begin
        state_d = state_q;
        hit_o   = 1'b0;
        pos     = '0;
        for (int p = 0; p < NUM_THREADS; p++) begin
            if (!hit_o && elig_i[state_q.order[p]]) begin
                hit_o = 1'b1;
                pos   = TID_W'(p);
            end
        end
        win_o = state_q.order[pos];
        if (advance_i && hit_o) begin
            for (int p = 0; p < NUM_THREADS - 1; p++) begin
                state_d.order[p] = (TID_W'(p) < pos) ? state_q.order[p]
                                                     : state_q.order[p+1];
            end
            state_d.order[NUM_THREADS-1] = win_o;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int p = 0; p < NUM_THREADS; p++) begin
                state_q.order[p] <= TID_W'(p);
            end
        end else begin
            state_q <= state_d;
        end
    end

    // every thread number appears exactly once in the list
    logic [NUM_THREADS-1:0] seen;
    always_comb begin
        seen = '0;
        for (int p = 0; p < NUM_THREADS; p++) begin
            seen[state_q.order[p]] = 1'b1;
        end
    end

    assert_list_perm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(seen) == NUM_THREADS);

    assert_winner_tail_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (advance_i && hit_o) |=> state_q.order[NUM_THREADS-1] == $past(win_o));

    assert_list_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !advance_i |=> $stable(state_q));

endmodule

// File: rtl/fsel_occ_pick.sv
module fsel_occ_pick #(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W       = 6,
    parameter int TID_W       = 2
) (
    input  logic [NUM_THREADS-1:0]       elig_i,
    input  logic [NUM_THREADS*CNT_W-1:0] occ_i,
    output logic                         hit_o,
    output logic [TID_W-1:0]             win_o
);

    logic [CNT_W-1:0] best;

    // strict compare keeps the lower index on equal counts
    always_comb begin
        hit_o = 1'b0;
        win_o = '0;
        best  = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (elig_i[t] && (!hit_o || occ_i[t*CNT_W +: CNT_W] > best)) begin
                hit_o = 1'b1;
                win_o = TID_W'(t);
                best  = occ_i[t*CNT_W +: CNT_W];
            end
        end
    end

endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W       = 6,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                                   clk_i,
    input  logic                                   rst_ni,
    input  logic [1:0]                             policy_i,
    input  logic [NUM_THREADS*3-1:0]               status_i,
    input  logic [NUM_THREADS-1:0]                 active_i,
    input  logic [NUM_THREADS*CNT_W-1:0]           occ_i,
    input  logic                                   take_i,
    output logic                                   valid_o,
    output logic [TID_W-1:0]                       tid_o
);
    import fsel_pkg::*;

    logic [NUM_THREADS-1:0] elig;
    logic                   rr_hit, occ_hit, advance;
    logic [TID_W-1:0]       rr_win, occ_win;

    fsel_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
        .status_i (status_i),
        .active_i (active_i),
        .elig_o   (elig)
    );

    fsel_rr_list #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_rr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .elig_i    (elig),
        .advance_i (advance),
        .hit_o     (rr_hit),
        .win_o     (rr_win)
    );

    fsel_occ_pick #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)) u_occ (
        .elig_i (elig),
        .occ_i  (occ_i),
        .hit_o  (occ_hit),
        .win_o  (occ_win)
    );

    if (NUM_THREADS == 1) begin : g_one
        assign valid_o = elig[0];
        assign tid_o   = '0;
        assign advance = 1'b0;
    end else begin : g_multi
        always_comb begin
            valid_o = 1'b0;
            tid_o   = '0;
            unique case (policy_e'(policy_i))
                POL_FIXED:  valid_o = 1'b1;
                POL_ROTATE: begin
                    valid_o = rr_hit;
                    tid_o   = rr_hit ? rr_win : '0;
                end
                POL_OCC: begin
                    valid_o = occ_hit;
                    tid_o   = occ_hit ? occ_win : '0;
                end
                default: valid_o = 1'b0;
            endcase
        end
        assign advance = take_i & valid_o & (policy_i == POL_ROTATE);

        // some eligible thread outranks the chosen one under the occupancy rule
        logic outranked;
        always_comb begin
            outranked = 1'b0;
            for (int t = 0; t < NUM_THREADS; t++) begin
                if (elig[t] && ((occ_i[t*CNT_W +: CNT_W] > occ_i[tid_o*CNT_W +: CNT_W]) ||
                    (occ_i[t*CNT_W +: CNT_W] == occ_i[tid_o*CNT_W +: CNT_W] &&
                     TID_W'(t) < tid_o))) begin
                    outranked = 1'b1;
                end
            end
        end

        assert_sel_eligible_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (valid_o && policy_i != POL_FIXED) |-> elig[tid_o]);

        assert_occ_max_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (valid_o && policy_i == POL_OCC) |-> !outranked);

        assert_bad_policy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            policy_i == POL_NONE |-> !valid_o);

        assert_fixed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            policy_i == POL_FIXED |-> (valid_o && tid_o == '0));
    end

    assert_idle_tid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> tid_o == '0);

endmodule

// File: tb/tb_fetch_thread_sel.sv
module tb_fetch_thread_sel;

    localparam int N  = 4;
    localparam int CW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [1:0]           pol = 2'd1;
    logic [N-1:0][2:0]    st = '0;
    logic [N-1:0]         act = '1;
    logic [N-1:0][CW-1:0] occ = '0;
    logic                 take = 1'b0;
    logic                 valid;
    logic [1:0]           tid;

    fetch_thread_sel #(.NUM_THREADS(N), .CNT_W(CW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .status_i(st),
        .active_i(act), .occ_i(occ), .take_i(take), .valid_o(valid), .tid_o(tid));

    logic [2:0] st1 = '0;
    logic       act1 = 1'b1;
    logic       valid1;
    logic [0:0] tid1;

    fetch_thread_sel #(.NUM_THREADS(1), .CNT_W(CW)) dut_one (
        .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .status_i(st1),
        .active_i(act1), .occ_i(occ[0]), .take_i(take), .valid_o(valid1), .tid_o(tid1));

    int checks = 0;
    int fails  = 0;

    typedef struct { bit v; int t; string req; } exp_t;
    exp_t exp_q[$];
    event drove;

    int mlist[N];

    function automatic bit ok(int t);
        return act[t] && (st[t] == 3'd0 || st[t] == 3'd1 || st[t] == 3'd6);
    endfunction

    task automatic drive(input logic [1:0] p, input logic [N-1:0][2:0] s,
                         input logic [N-1:0] a, input logic [N-1:0][CW-1:0] o,
                         input bit tk, input string req);
        exp_t e;
        int pos;
        @(negedge clk);
        pol = p; st = s; act = a; occ = o; take = tk;
        e.v = 0; e.t = 0; e.req = req; pos = 0;
        case (p)
            2'd0: e.v = 1;
            2'd1: for (int i = 0; i < N; i++)
                      if (!e.v && ok(mlist[i])) begin e.v = 1; e.t = mlist[i]; pos = i; end
            2'd2: for (int t = 0; t < N; t++)
                      if (ok(t) && (!e.v || o[t] > o[e.t])) begin e.v = 1; e.t = t; end
            default: e.v = 0;
        endcase
        exp_q.push_back(e);
        ->drove;
        if (tk && e.v && p == 2'd1) begin
            for (int i = pos; i < N - 1; i++) mlist[i] = mlist[i+1];
            mlist[N-1] = e.t;
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(drove);
            #1;
            e = exp_q.pop_front();
            checks++;
            if (valid !== e.v || int'(tid) !== e.t) begin
                fails++;
                $display("FAIL %s: got valid=%0d tid=%0d, expected valid=%0d tid=%0d",
                         e.req, valid, tid, e.v, e.t);
            end
        end
    end

    task automatic check_one(input bit ev, input string req);
        #2;
        checks++;
        if (valid1 !== ev || tid1 !== 1'b0) begin
            fails++;
            $display("FAIL %s: got valid=%0d tid=%0d, expected valid=%0d tid=0",
                     req, valid1, tid1, ev);
        end
    endtask

    localparam logic [N-1:0][2:0] ALLRUN = '0;
    localparam logic [N-1:0][CW-1:0] OCC0 = '0;

    initial begin : stim
        for (int i = 0; i < N; i++) mlist[i] = i;
        repeat (3) @(posedge clk);
        // R5: combinational choice reflects the reset list order
        drive(2'd1, ALLRUN, 4'hF, OCC0, 0, "R5 reset order");
        rst_n = 1'b1;
        drive(2'd1, ALLRUN, 4'hF, OCC0, 0, "R5 head after reset");
        drive(2'd1, ALLRUN, 4'hF, OCC0, 1, "R3 take thread 0");
        drive(2'd1, ALLRUN, 4'hF, OCC0, 1, "R3 take thread 1");
        drive(2'd1, {3'd0, 3'd3, 3'd0, 3'd0}, 4'hF, OCC0, 1, "R2 skip blocked head");
        drive(2'd1, ALLRUN, 4'hF, OCC0, 0, "R3 order kept");
        drive(2'd1, {3'd4, 3'd2, 3'd6, 3'd1}, 4'hF, OCC0, 1, "R1 idle and fill-done eligible");
        drive(2'd1, ALLRUN, 4'b1101, OCC0, 0, "R1 inactive thread excluded");
        drive(2'd1, ALLRUN, 4'b0000, OCC0, 0, "R1 all inactive");
        drive(2'd1, {3'd7, 3'd5, 3'd4, 3'd2}, 4'hF, OCC0, 1, "R4 nothing eligible");
        drive(2'd1, ALLRUN, 4'hF, OCC0, 0, "R9 invalid take left list");
        drive(2'd2, {3'd3, 3'd0, 3'd0, 3'd0}, 4'hF, {6'd20, 6'd9, 6'd9, 6'd5}, 1,
              "R7 blocked max, tie to lower");
        drive(2'd1, ALLRUN, 4'hF, OCC0, 0, "R9 occupancy take left list");
        drive(2'd2, ALLRUN, 4'hF, {6'd63, 6'd1, 6'd40, 6'd2}, 0, "R7 largest count");
        drive(2'd2, {3'd3, 3'd3, 3'd3, 3'd3}, 4'hF, {6'd63, 6'd1, 6'd40, 6'd2}, 0, "R4 occupancy none");
        drive(2'd0, {3'd3, 3'd3, 3'd3, 3'd3}, 4'h0, OCC0, 1, "R6 fixed policy");
        drive(2'd3, ALLRUN, 4'hF, OCC0, 1, "R8 unsupported policy");
        drive(2'd1, ALLRUN, 4'hF, OCC0, 1, "R9 list after fixed and unsupported takes");
        drive(2'd1, ALLRUN, 4'hF, OCC0, 0, "R3 next head");
        // R10: one-thread build ignores the policy code
        st1 = 3'd0; act1 = 1'b1;
        drive(2'd3, ALLRUN, 4'hF, OCC0, 0, "R8 unsupported again");
        check_one(1, "R10 policy ignored, running");
        st1 = 3'd3;
        drive(2'd2, ALLRUN, 4'hF, OCC0, 0, "R7 all zero counts");
        check_one(0, "R10 blocked thread");
        st1 = 3'd6; act1 = 1'b0;
        drive(2'd0, ALLRUN, 4'hF, OCC0, 0, "R6 fixed again");
        check_one(0, "R10 inactive thread");
        act1 = 1'b1;
        drive(2'd0, ALLRUN, 4'hF, OCC0, 0, "R6 fixed once more");
        check_one(1, "R10 fill-done thread");
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule